// File: doc/BRIEF.md
# Serial Engine in SPI Master Mode

This block is a byte-wide serial engine that runs as an SPI master once a two-bit mode field selects that mode. The mode field can also hold the two USART framing codes and one reserved code. This build implements only the SPI master path, and it generates no SCK activity under any of the other codes. Software reaches the block through a small register bus. Writing a byte to the data register fills a one-entry transmit buffer. The buffer moves into a shift register as soon as the shifter is idle, so the next byte can be queued while the current byte is still on the wire.

Each byte takes sixteen SCK edges. The block samples MISO and updates MOSI on opposite edges, as chosen by the clock phase bit. A polarity bit sets the idle level of SCK, and an order bit selects LSB-first or MSB-first shifting. A divider register sets the SCK rate from the system clock. The received byte lands in a receive buffer that software reads back through the data register. Two interrupt lines report "transmit buffer empty" and "transfer finished". Each line is gated by its own enable and by a global interrupt enable input.

Top module: `spim_engine`

## Requirements
- R1: The mode field is ctrl-C bits 7:6. Code 11 runs SPI master transfers. With codes 00, 01 and 10, SCK never toggles and a queued byte stays in the transmit buffer. The queued byte is sent once code 11 is written.
- R2: The order, phase and polarity bits (ctrl-C bits 2, 1 and 0) can be written in the same write that sets code 11. They apply to the very next transfer.
- R3: When ctrl-C bit 2 is 1, the byte is shifted LSB first. When it is 0, the byte is shifted MSB first. The same order applies to MOSI and MISO.
- R4: SCK idles at the ctrl-C bit 0 level. With phase 0 (bit 1 = 0), MISO is sampled on leading edges and MOSI changes on trailing edges. With phase 1, the roles of the two edges are reversed.
- R5: With divider register (address 4) value D, each SCK half period lasts D+1 clocks. One byte takes 16 edges, and its first and last edges are 15*(D+1) clocks apart.
- R6: When a transfer completes with the receiver enabled, the received byte can be read at address 0. Status bit 7 (receive complete) is set at the same time. A read at address 0 with the pop strobe clears status bit 7.
- R7: When the receiver is enabled (ctrl-B bit 4) but the transmitter is not (ctrl-B bit 3), no SCK edges occur. In that state, writes to the data register are ignored and the buffer-empty flag stays 1.
- R8: After ctrl-B bit 3 is cleared, the transmitter keeps running until both the buffer and the shifter are empty. Both queued bytes still go out, and the port-drive output stays 1 until the end of the last byte.
- R9: Clearing ctrl-B bit 4 flushes the receive buffer. Status bit 7 reads 0 and address 0 reads 0.
- R10: The buffer-empty flag (status bit 5) is 1 after reset. A data write clears it, and it is set again when the buffer moves to the shifter. irq_dre is 1 exactly when ctrl-B bit 5, gie and this flag are all 1.
- R11: The transfer-finished flag (status bit 6) sets when the last edge completes and the buffer is empty. It is cleared by txc_ack or by writing 1 to status bit 6. irq_txc is 1 exactly when ctrl-B bit 6, gie and this flag are all 1.
- R12: Ctrl-B bits 2:0 always read 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register address (0 data, 1 status, 2 ctrl-B, 3 ctrl-C, 4 divider) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read pop strobe (clears receive complete on address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| gie | input | 1 | Global interrupt enable |
| txc_ack | input | 1 | Acknowledge of the transfer-finished interrupt |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| tx_drive | output | 1 | Transmitter owns the MOSI/SCK pins |
| irq_txc | output | 1 | Transfer-finished interrupt request |
| irq_dre | output | 1 | Buffer-empty interrupt request |

## Verification
The bench acts as an SPI slave and runs seeded random bytes through all eight combinations of order, phase and polarity, at divider values 0 to 3. A bit-order error therefore shows up as a reversed byte, a phase error as a byte shifted by one bit, and a divider error as a wrong edge spacing. Directed sequences cover the cases that the random traffic cannot reach. These include a byte queued under a non-SPI mode code, a receiver enabled without the transmitter, and the transmitter being disabled while two bytes are still pending. They also include a receiver flush, and the interrupt gating with gie set both high and low.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_SPIM  = 2'b11
  } mode_e;

  typedef struct packed {
    logic lsb_first;
    logic cpha;
    logic cpol;
  } fmt_t;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTLB = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTLC = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

  localparam int ST_RXC   = 7;
  localparam int ST_TXC   = 6;
  localparam int CB_TXCIE = 6;
  localparam int CB_DREIE = 5;
  localparam int CB_RXEN  = 4;
  localparam int CB_TXEN  = 3;
  localparam int CC_ORD   = 2;
  localparam int CC_PHA   = 1;
  localparam int CC_POL   = 0;

  function automatic fmt_t fmt_from_reg(input logic [REG_W-1:0] v);
    fmt_t f;
    f.lsb_first = v[CC_ORD];
    f.cpha      = v[CC_PHA];
    f.cpol      = v[CC_POL];
    return f;
  endfunction
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  fmt_t              load_fmt,
  input  logic              idle_cpol,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int EDGE_W = IDX_W + 1;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2*DATA_W-1);

  function automatic logic [IDX_W-1:0] slot(input logic [IDX_W-1:0] pos, input logic lsb);
    return lsb ? pos : (IDX_W'(DATA_W-1) - pos);
  endfunction

  logic              busy_q, lvl_q, mosi_q;
  logic [EDGE_W-1:0] edge_q;
  logic [EDGE_W:0]   edge_inc;
  logic [IDX_W-1:0]  out_pos, smp_pos;
  logic [DATA_W-1:0] tx_q, rx_q;
  fmt_t              fmt_q;
  logic              sample_evt, change_evt, out_ok;

  assign edge_inc   = {1'b0, edge_q} + (EDGE_W+1)'(1);
  assign out_pos    = edge_inc[IDX_W:1];
  assign smp_pos    = edge_q[EDGE_W-1:1];
  assign out_ok     = (edge_q != LAST_EDGE);
  assign sample_evt = busy_q && tick && (edge_q[0] == fmt_q.cpha);
  assign change_evt = busy_q && tick && (edge_q[0] != fmt_q.cpha);
  assign done       = busy_q && tick && (edge_q == LAST_EDGE);

  always_comb begin
    rx_word = rx_q;
    if (sample_evt) rx_word[slot(smp_pos, fmt_q.lsb_first)] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      mosi_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      fmt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      lvl_q  <= 1'b0;
      edge_q <= '0;
      tx_q   <= load_data;
      rx_q   <= '0;
      fmt_q  <= load_fmt;
      if (!load_fmt.cpha) mosi_q <= load_data[slot('0, load_fmt.lsb_first)];
    end else if (busy_q && tick) begin
      lvl_q  <= ~lvl_q;
      edge_q <= edge_q + EDGE_W'(1);
      rx_q   <= rx_word;
      if (change_evt && out_ok) mosi_q <= tx_q[slot(out_pos, fmt_q.lsb_first)];
      if (done) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign sck  = busy_q ? (fmt_q.cpol ^ lvl_q) : idle_cpol;
  assign mosi = mosi_q;
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              gie,
  input  logic              txc_ack,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              tx_drive,
  output logic              irq_txc,
  output logic              irq_dre
);
  mode_e            mode_q;
  fmt_t             fmt_q;
  logic [REG_W-1:0] div_q, tx_buf, rx_buf;
  logic             txc_ie, dre_ie, rx_en, tx_en;
  logic             buf_full, txc, rx_full;

  // named internal events
  logic             mode_spi, busy, tick, done, load, data_accept, dre;
  logic             wr_stat, wr_ctlb, wr_ctlc, wr_div, pop_rx;
  logic [REG_W-1:0] rx_word;

  assign mode_spi    = (mode_q == MODE_SPIM);
  assign dre         = !buf_full;
  assign tx_drive    = tx_en || buf_full || busy;
  assign data_accept = bus_wr && (bus_addr == A_DATA) && tx_en && !buf_full;
  assign load        = mode_spi && buf_full && !busy;
  assign wr_stat     = bus_wr && (bus_addr == A_STAT);
  assign wr_ctlb     = bus_wr && (bus_addr == A_CTLB);
  assign wr_ctlc     = bus_wr && (bus_addr == A_CTLC);
  assign wr_div      = bus_wr && (bus_addr == A_DIV);
  assign pop_rx      = bus_rd && (bus_addr == A_DATA);

  spim_baud #(.CNT_W(REG_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  spim_shifter #(.DATA_W(REG_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(tx_buf),
    .load_fmt(fmt_q), .idle_cpol(fmt_q.cpol), .tick(tick), .miso(miso),
    .busy(busy), .sck(sck), .mosi(mosi), .done(done), .rx_word(rx_word)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ASYNC;
      fmt_q  <= '0;
      div_q  <= '0;
      txc_ie <= 1'b0;
      dre_ie <= 1'b0;
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
    end else begin
      if (wr_ctlc) begin
        mode_q <= mode_e'(bus_wdata[7:6]);
        fmt_q  <= fmt_from_reg(bus_wdata);
      end
      if (wr_div) div_q <= bus_wdata;
      if (wr_ctlb) begin
        txc_ie <= bus_wdata[CB_TXCIE];
        dre_ie <= bus_wdata[CB_DREIE];
        rx_en  <= bus_wdata[CB_RXEN];
        tx_en  <= bus_wdata[CB_TXEN];
      end
    end
  end

  // transmit buffer and completion flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      buf_full <= 1'b0;
      txc      <= 1'b0;
    end else begin
      if (data_accept) begin
        tx_buf   <= bus_wdata;
        buf_full <= 1'b1;
      end else if (load) begin
        buf_full <= 1'b0;
      end
      if (done && !buf_full)                          txc <= 1'b1;
      else if (txc_ack || (wr_stat && bus_wdata[ST_TXC])) txc <= 1'b0;
    end
  end

  // receive buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
    end else if (!rx_en) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
    end else if (done) begin
      rx_buf  <= rx_word;
      rx_full <= 1'b1;
    end else if (pop_rx) begin
      rx_full <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rx_buf;
      A_STAT:  bus_rdata = {rx_full, txc, dre, 5'b00000};
      A_CTLB:  bus_rdata = {1'b0, txc_ie, dre_ie, rx_en, tx_en, 3'b000};
      A_CTLC:  bus_rdata = {mode_q, 3'b000, fmt_q.lsb_first, fmt_q.cpha, fmt_q.cpol};
      A_DIV:   bus_rdata = div_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_txc = txc_ie && gie && txc;
  assign irq_dre = dre_ie && gie && dre;
endmodule

// File: rtl/spim_checker.sv
module spim_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cpol_cfg,
  input logic       busy,
  input logic       mode_spi,
  input logic       tx_drive,
  input logic       rx_en,
  input logic       rx_full,
  input logic       data_accept,
  input logic       dre,
  input logic       txc,
  input logic       txc_ack,
  input logic       done,
  input logic       gie,
  input logic       irq_txc,
  input logic       irq_dre,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_rdata
);
  assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol_cfg));

  assert_start_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode_spi));

  assert_drive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tx_drive);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_full);

  assert_dre_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_accept |=> !dre);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dre |-> (gie && dre));

  assert_txc_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_ack && !done) |=> !txc);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txc |-> (gie && txc));

  assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd2) |-> (bus_rdata[2:0] == 3'b000));
endmodule

bind spim_engine spim_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cpol_cfg(fmt_q.cpol), .busy(busy),
  .mode_spi(mode_spi), .tx_drive(tx_drive), .rx_en(rx_en), .rx_full(rx_full),
  .data_accept(data_accept), .dre(dre), .txc(txc), .txc_ack(txc_ack),
  .done(done), .gie(gie), .irq_txc(irq_txc), .irq_dre(irq_dre),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/sim_spim_engine.sv
module sim_spim_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0, txc_ack = 1'b0, miso = 1'b0;
  logic       sck, mosi, tx_drive, irq_txc, irq_dre;

  always #5 clk = ~clk;

  spim_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie), .txc_ack(txc_ack),
    .miso(miso), .sck(sck), .mosi(mosi), .tx_drive(tx_drive),
    .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  // slave model state
  bit guard = 1'b1;
  logic prev_sck = 1'b0;
  bit s_lsb = 1'b0, s_cpha = 1'b0;
  int sn = 0, edges = 0, first_cyc = -1, last_cyc = -1;
  logic [7:0] resp = '0, s_rx = '0, hist0 = '0, hist1 = '0;

  function automatic int slot(input int idx, input bit lsb);
    return lsb ? idx : 7 - idx;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // SPI slave: runs 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sck !== prev_sck && !guard && rst_n) begin
        int old;
        old = sn;
        if (old[0] == s_cpha) s_rx[slot(old >> 1, s_lsb)] = mosi;
        sn = old + 1;
        edges++;
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        if (sn == 16) begin
          hist1 = hist0;
          hist0 = s_rx;
          sn = 0;
        end
        miso = resp[slot(sn >> 1, s_lsb)];
      end
      prev_sck = sck;
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    guard = 1'b1;
    bus_write(a, d);
    guard = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input bit pop, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = pop;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic prep_slave(input logic [7:0] rsp, input bit lsb, input bit cpha);
    resp = rsp; s_lsb = lsb; s_cpha = cpha;
    sn = 0; edges = 0; first_cyc = -1; last_cyc = -1;
    miso = rsp[slot(0, lsb)];
  endtask

  task automatic wait_txc(input string req);
    logic [7:0] v;
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      bus_read(3'd1, 1'b0, v);
      seen = v[6];
    end
    chk(seen, req, 0, 1);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    guard = 1'b0;
    @(negedge clk);

    // reset state
    bus_read(3'd1, 1'b0, v);
    chk(v == 8'h20, "R10 reset status", v, 8'h20);
    chk(irq_txc == 0 && irq_dre == 0, "R10 reset irq", {irq_txc, irq_dre}, 0);
    chk(sck == 0 && tx_drive == 0, "R4 reset sck/drive", {sck, tx_drive}, 0);

    // R12 reserved bits
    bus_write(3'd2, 8'h1F);
    bus_read(3'd2, 1'b0, v);
    chk(v == 8'h18, "R12 reserved read", v, 8'h18);

    // R1: byte queued in synchronous-USART code does not shift
    cfg_write(3'd3, 8'h40);
    prep_slave(8'h3C, 1'b0, 1'b0);
    bus_write(3'd0, 8'hA5);
    repeat (40) @(negedge clk);
    chk(edges == 0, "R1 no edges in mode 01", edges, 0);
    bus_read(3'd1, 1'b0, v);
    chk(v[5] == 1'b0, "R1 buffer still held", v[5], 0);
    bus_write(3'd4, 8'd1);
    cfg_write(3'd3, 8'hC0);
    wait_txc("R1 transfer after mode 11");
    chk(hist0 == 8'hA5, "R1 slave byte", hist0, 8'hA5);
    chk(last_cyc - first_cyc == 30, "R5 spacing div1", last_cyc - first_cyc, 30);
    bus_read(3'd0, 1'b1, v);
    chk(v == 8'h3C, "R6 rx byte", v, 8'h3C);
    bus_read(3'd1, 1'b0, v);
    chk(v[7] == 1'b0, "R6 pop clears rxc", v[7], 0);
    bus_write(3'd1, 8'h40);

    // R7 receiver only
    bus_write(3'd2, 8'h10);
    prep_slave(8'h11, 1'b0, 1'b0);
    bus_write(3'd0, 8'h77);
    repeat (30) @(negedge clk);
    chk(edges == 0, "R7 no edges rx only", edges, 0);
    bus_read(3'd1, 1'b0, v);
    chk(v[5] == 1'b1, "R7 write ignored", v[5], 1);

    // R9 flush
    bus_write(3'd2, 8'h18);
    prep_slave(8'h5A, 1'b0, 1'b0);
    bus_write(3'd0, 8'hC3);
    wait_txc("R9 transfer");
    bus_read(3'd1, 1'b0, v);
    chk(v[7] == 1'b1, "R6 rxc set", v[7], 1);
    bus_write(3'd1, 8'h40);
    bus_write(3'd2, 8'h08);
    bus_read(3'd1, 1'b0, v);
    chk(v[7] == 1'b0, "R9 flag flushed", v[7], 0);
    bus_read(3'd0, 1'b0, v);
    chk(v == 8'h00, "R9 data flushed", v, 0);

    // R8 deferred disable
    bus_write(3'd2, 8'h18);
    bus_write(3'd4, 8'd3);
    prep_slave(8'h0F, 1'b0, 1'b0);
    bus_write(3'd0, 8'h81);
    begin
      bit moved = 1'b0;
      for (int i = 0; i < 200 && !moved; i++) begin
        bus_read(3'd1, 1'b0, v);
        moved = v[5];
      end
      chk(moved, "R10 dre set on move", v[5], 1);
    end
    bus_write(3'd0, 8'h7E);
    bus_write(3'd2, 8'h10);
    chk(tx_drive == 1'b1, "R8 drive held", tx_drive, 1);
    begin
      bit rel = 1'b0;
      for (int i = 0; i < 3000 && !rel; i++) begin
        @(negedge clk);
        rel = !tx_drive;
      end
    end
    chk(edges == 32, "R8 both bytes clocked", edges, 32);
    chk(hist1 == 8'h81 && hist0 == 8'h7E, "R8 byte order", {hist1, hist0}, 16'h817E);
    chk(tx_drive == 1'b0, "R8 released", tx_drive, 0);

    // R10 / R11 interrupts
    bus_write(3'd1, 8'h40);
    bus_write(3'd2, 8'h78);
    @(negedge clk);
    chk(irq_dre == 0, "R10 irq_dre gie=0", irq_dre, 0);
    gie = 1'b1;
    #1 chk(irq_dre == 1, "R10 irq_dre gie=1", irq_dre, 1);
    prep_slave(8'h00, 1'b0, 1'b0);
    bus_write(3'd0, 8'h42);
    chk(irq_dre == 0, "R10 irq_dre after write", irq_dre, 0);
    wait_txc("R11 txc set");
    @(negedge clk);
    chk(irq_txc == 1, "R11 irq_txc", irq_txc, 1);
    txc_ack = 1'b1;
    @(negedge clk);
    txc_ack = 1'b0;
    chk(irq_txc == 0, "R11 ack clears", irq_txc, 0);
    prep_slave(8'h00, 1'b0, 1'b0);
    bus_write(3'd0, 8'h24);
    wait_txc("R11 txc again");
    bus_write(3'd1, 8'h40);
    bus_read(3'd1, 1'b0, v);
    chk(v[6] == 0, "R11 write-1 clears", v[6], 0);
    gie = 1'b0;

    // random transfers over all formats (R2..R6)
    void'($urandom(32'd1234));
    for (int it = 0; it < 16; it++) begin
      logic [7:0] tx, rsp;
      bit lsb, cpha, cpol;
      int div;
      tx = 8'($urandom); rsp = 8'($urandom);
      lsb = it[0]; cpha = it[1]; cpol = it[2];
      div = $urandom_range(0, 3);
      bus_write(3'd4, 8'(div));
      cfg_write(3'd3, 8'h00);
      prep_slave(rsp, lsb, cpha);
      cfg_write(3'd3, {2'b11, 3'b000, lsb, cpha, cpol});
      bus_write(3'd0, tx);
      wait_txc("R2 random done");
      chk(hist0 == tx, "R3 R2 mosi byte", hist0, tx);
      chk(edges == 16, "R5 edge count", edges, 16);
      chk(last_cyc - first_cyc == 15 * (div + 1), "R5 spacing",
          last_cyc - first_cyc, 15 * (div + 1));
      bus_read(3'd0, 1'b1, v);
      chk(v == rsp, "R4 R6 miso byte", v, rsp);
      chk(sck == cpol, "R4 idle level", sck, cpol);
      bus_write(3'd1, 8'h40);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule